// File: doc/BRIEF.md
# Period-Gated Round-Robin Sub-Link Scheduler

This block decides which sub-link of a single virtual link may send next. The link is split into several sub-links, each with its own frame queue held elsewhere, and the block sees only a not-empty flag per queue. A free-running timer divides time into allocation periods whose length is a programmable number of clock ticks. At each period boundary the block grants at most one frame or fragment. It searches the queues in round-robin order, starting at the sub-link after the one served last, so a long fragmented transfer on one sub-link cannot crowd out short periodic messages on the others.

A grant names one sub-link and comes with a single-cycle start strobe. The grant stays up until the transmitter reports completion on the done input. If a boundary arrives while a grant is still outstanding, that period passes unused, so two strobes are never closer together than one period. Dropping the enable input stops new grants, restarts the timer and returns the search pointer to sub-link 0.

Top module: `sublink_sched_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) grant_valid and tx_start are 0 and the search pointer is sub-link 0, so the first grant after reset with all queues non-empty names sub-link 0.
- R2: While enable is high, period boundaries occur every max(bag_period, 1) clock cycles. The first boundary falls on the first clock edge at which enable is high. A bag_period of 0 behaves as 1.
- R3: A grant is issued only at a boundary edge when no grant is held and at least one queue flag is set. At that edge grant_valid rises, grant_sel takes the chosen index, and tx_start is high for exactly one cycle. With done returned promptly, consecutive strobes are exactly one period apart.
- R4: The search starts at the pointer and moves upward through the indices, wrapping from 3 to 0. Queues whose q_nonempty bit (bit i belongs to sub-link i) is 0 are skipped within the same boundary.
- R5: After a grant to sub-link k the pointer becomes k+1, or 0 when k is the last index.
- R6: At a boundary where every queue flag is 0, no grant is issued and the pointer keeps its value.
- R7: A held grant keeps grant_valid high and grant_sel unchanged until tx_done is sampled high. grant_valid is low from the following cycle on.
- R8: A boundary that finds a grant held issues no grant, even when tx_done is sampled at that same edge. The next opportunity is the following boundary.
- R9: With enable low, no grant is issued and the pointer is 0. A grant already held still waits for tx_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Scheduling enable. Low stops grants and restarts the timer and the pointer |
| bag_period | input | 16 | Allocation period in clock ticks (0 treated as 1) |
| q_nonempty | input | 4 | Per-sub-link queue-not-empty flags |
| tx_done | input | 1 | Transmitter completion of the granted frame |
| grant_valid | output | 1 | A grant is outstanding |
| grant_sel | output | 2 | Index of the granted sub-link |
| tx_start | output | 1 | One-cycle strobe marking a new grant |

## Verification
The assertions check on every cycle that a strobe only follows a boundary, that it never coincides with a grant already held, and that the granted queue was flagged. They also check that a held grant stays put until done, that a disabled scheduler issues nothing and keeps its pointer at 0, and that an idle boundary leaves the pointer alone. Only the directed scenarios can show the period spacing as a count of cycles, the rotation order with skipped queues, and that a pointer survives empty periods. They also show the lost period when done lands on a boundary, and the restart at sub-link 0 after enable is cleared.

// File: rtl/sublink_sched_pkg.sv
// Package: shared helpers for the sub-link scheduler.
// Assumes index values fit in 32 bits.
package sublink_sched_pkg;

    // Upper bound on the sub-link count this code base supports.
    localparam int unsigned SUBLINK_LIMIT = 16;

    // Next round-robin index after cur, wrapping at count.
    function automatic int unsigned rr_next(input int unsigned cur, input int unsigned count);
        return (cur + 1 >= count) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/bag_timer.sv
// Module: bag_timer
// Free-running allocation-period counter. It raises a boundary flag on the
// cycle its phase is zero while enabled. Assumes the period may change at any
// time. A shrink takes effect at the next wrap check, and a 0 period acts as 1.
module bag_timer #(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    output logic                boundary
);
    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    logic [PERIOD_W-1:0] phase;
    logic [PERIOD_W-1:0] eff_period;
    logic [PERIOD_W-1:0] last_phase;

    // Clamp the programmed period to at least one tick.
    always_comb begin
        eff_period = (period == '0) ? ONE : period;
        last_phase = eff_period - ONE;
    end

    // Advance the phase and wrap at the end of the period; hold at 0 when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= '0;
        end else if (phase >= last_phase) begin
            phase <= '0;
        end else begin
            phase <= phase + ONE;
        end
    end

    // A boundary is the first tick of each period.
    assign boundary = enable && (phase == '0);

    // R2: with a period above one tick, boundaries never fall on adjacent cycles.
    a_r2_boundary_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && enable && $stable(period) && eff_period != ONE) |=> !boundary);

endmodule

// File: rtl/rr_picker.sv
// Module: rr_picker
// Combinational round-robin selector. Starting at ptr and moving upward with
// wrap, it returns the first requesting index. Assumes ptr < N_SUB.
module rr_picker #(
    parameter int unsigned N_SUB = 4,
    localparam int unsigned IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
    input  logic [N_SUB-1:0] req,
    input  logic [IDX_W-1:0] ptr,
    output logic             found,
    output logic [IDX_W-1:0] pick
);
    logic [IDX_W-1:0] cand_idx [N_SUB];
    logic [N_SUB-1:0] cand_hit;

    // One candidate per search offset: index ptr+g folded into range.
    for (genvar g = 0; g < N_SUB; g++) begin : g_cand
        logic [IDX_W:0] sum;
        // Compute the wrapped index for this offset.
        always_comb begin
            sum = {1'b0, ptr} + (IDX_W+1)'(g);
            if (sum >= (IDX_W+1)'(N_SUB)) begin
                sum = sum - (IDX_W+1)'(N_SUB);
            end
            cand_idx[g] = sum[IDX_W-1:0];
            cand_hit[g] = req[cand_idx[g]];
        end
    end

    // Pick the lowest offset that hits; scan high to low so the last write wins.
    always_comb begin
        found = |cand_hit;
        pick  = ptr;
        for (int k = N_SUB - 1; k >= 0; k--) begin
            if (cand_hit[k]) begin
                pick = cand_idx[k];
            end
        end
    end

endmodule

// File: rtl/grant_ctrl.sv
// Module: grant_ctrl
// Holds one outstanding grant and the round-robin pointer. It issues a grant
// only at a boundary with no grant held and a requester found, then waits for
// tx_done. Assumes found/pick come from a picker fed by this ptr.
module grant_ctrl
    import sublink_sched_pkg::*;
#(
    parameter int unsigned N_SUB = 4,
    localparam int unsigned IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             boundary,
    input  logic             pick_found,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             tx_done,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_sel,
    output logic             tx_start,
    output logic [IDX_W-1:0] ptr
);
    logic issue;

    // A new grant needs a boundary, an idle grant slot and a requester.
    assign issue = enable && boundary && !grant_valid && pick_found;

    // Update grant, strobe and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_sel   <= '0;
            tx_start    <= 1'b0;
            ptr         <= '0;
        end else begin
            tx_start <= issue;
            if (grant_valid && tx_done) begin
                grant_valid <= 1'b0;
            end
            if (issue) begin
                grant_valid <= 1'b1;
                grant_sel   <= pick_idx;
            end
            if (!enable) begin
                ptr <= '0;
            end else if (issue) begin
                ptr <= IDX_W'(rr_next(int'(pick_idx), N_SUB));
            end
        end
    end

    // R7: a grant not released by done keeps its value.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grant_valid) && !$past(tx_done)) |-> (grant_valid && $stable(grant_sel)));

    // R7: done on a held grant drops it.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grant_valid) && $past(tx_done)) |-> !grant_valid);

    // R8: no strobe while the previous grant was still held.
    a_r8_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !$past(grant_valid));

    // R3: the strobe lasts one cycle and always comes with a grant.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    a_r3_strobe_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> grant_valid);

    // R9: disabled cycles leave no strobe and a zero pointer.
    a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!tx_start && ptr == '0));

    // R6: an enabled cycle with no requester leaves the pointer alone.
    a_r6_idle_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !$past(pick_found)) |-> $stable(ptr));

endmodule

// File: rtl/sublink_sched_top.sv
// Module: sublink_sched_top
// Period-gated round-robin scheduler for the sub-links of one virtual link.
// It joins the period timer, the round-robin picker and the grant holder.
// Assumes queue flags are synchronous to clk and tx_done refers to the grant.
module sublink_sched_top #(
    parameter int unsigned N_SUB    = 4,
    parameter int unsigned PERIOD_W = 16,
    localparam int unsigned IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] bag_period,
    input  logic [N_SUB-1:0]    q_nonempty,
    input  logic                tx_done,
    output logic                grant_valid,
    output logic [IDX_W-1:0]    grant_sel,
    output logic                tx_start
);
    logic             boundary;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] ptr;

    bag_timer #(.PERIOD_W(PERIOD_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .period   (bag_period),
        .boundary (boundary)
    );

    rr_picker #(.N_SUB(N_SUB)) i_picker (
        .req   (q_nonempty),
        .ptr   (ptr),
        .found (pick_found),
        .pick  (pick_idx)
    );

    grant_ctrl #(.N_SUB(N_SUB)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .boundary    (boundary),
        .pick_found  (pick_found),
        .pick_idx    (pick_idx),
        .tx_done     (tx_done),
        .grant_valid (grant_valid),
        .grant_sel   (grant_sel),
        .tx_start    (tx_start),
        .ptr         (ptr)
    );

    // R3: every strobe follows a period boundary from the timer.
    a_r3_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(boundary));

    // R4: the granted sub-link had its queue flag set at the deciding edge.
    a_r4_granted_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> ((($past(q_nonempty) >> grant_sel) & N_SUB'(1)) != '0));

endmodule

// File: tb/test_sublink_sched_top.sv
// Directed bench for sublink_sched_top: one task per scenario.
module test_sublink_sched_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [15:0] bag_period;
    logic [3:0]  q_nonempty;
    logic        tx_done;
    logic        grant_valid;
    logic [1:0]  grant_sel;
    logic        tx_start;

    int cyc = 0;
    int last_strobe = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    sublink_sched_top i_sublink_sched_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bag_period(bag_period),
        .q_nonempty(q_nonempty), .tx_done(tx_done), .grant_valid(grant_valid),
        .grant_sel(grant_sel), .tx_start(tx_start)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait for a strobe; check its sub-link and the gap since the previous one
    // (exp_gap < 0 skips the gap). Return done after done_delay cycles
    // (done_delay < 0: leave the grant held). While held, the grant must not move.
    task automatic serve(input int exp_sel, input int exp_gap, input string req,
                         input int done_delay);
        int waited = 0;
        bit held_ok = 1'b1;
        int gap;
        do begin
            @(negedge clk);
            waited++;
        end while (!tx_start && waited < 300);
        check(tx_start == 1'b1, req, "strobe seen", int'(tx_start), 1);
        gap = cyc - last_strobe;
        last_strobe = cyc;
        check(int'(grant_sel) == exp_sel && grant_valid, req, "grant_sel",
              int'(grant_sel), exp_sel);
        if (exp_gap >= 0) check(gap == exp_gap, req, "strobe gap", gap, exp_gap);
        if (done_delay >= 0) begin
            for (int i = 0; i < done_delay; i++) begin
                @(negedge clk);
                if (!grant_valid || tx_start || int'(grant_sel) != exp_sel) held_ok = 1'b0;
            end
            if (done_delay > 0) check(held_ok, "R7", "grant held before done",
                                      int'(held_ok), 1);
            tx_done = 1'b1;
            @(negedge clk);
            tx_done = 1'b0;
            check(!grant_valid, "R7", "grant dropped after done", int'(grant_valid), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b1; bag_period = 16'd4; q_nonempty = 4'b1111; tx_done = 1'b0;
        repeat (3) @(negedge clk);
        check(!grant_valid, "R1", "grant_valid in reset", int'(grant_valid), 0);
        check(!tx_start, "R1", "tx_start in reset", int'(tx_start), 0);
        rst_n = 1'b1;
        last_strobe = cyc;
        serve(0, 1, "R1", 0);
    endtask

    task automatic t_rotation();
        // R3 R5: full rotation with a 4-cycle period.
        serve(1, 4, "R3", 0);
        serve(2, 4, "R5", 0);
        serve(3, 4, "R5", 0);
        serve(0, 4, "R5", 0);
    endtask

    task automatic t_skip();
        // R4: empty queues 0 and 2 are skipped within the boundary.
        q_nonempty = 4'b1010;
        serve(1, 4, "R4", 0);
        serve(3, 4, "R4", 0);
        serve(1, 4, "R4", 0);
    endtask

    task automatic t_idle();
        bit quiet = 1'b1;
        // R6: idle periods issue nothing and keep the pointer at 2.
        q_nonempty = 4'b0000;
        repeat (13) begin
            @(negedge clk);
            if (tx_start || grant_valid) quiet = 1'b0;
        end
        check(quiet, "R6", "no grant while all empty", int'(quiet), 1);
        q_nonempty = 4'b1111;
        serve(2, -1, "R6", 3);
    endtask

    task automatic t_done_on_boundary();
        // R8: done sampled at a boundary edge forfeits that period.
        serve(3, 8, "R8", 0);
    endtask

    task automatic t_period();
        // R2: period of 6, then 0 acting as 1.
        bag_period = 16'd6;
        serve(0, -1, "R2", 0);
        serve(1, 6, "R2", 0);
        serve(2, 6, "R2", 0);
        bag_period = 16'd0;
        serve(3, -1, "R2", 0);
        serve(0, 2, "R2", 0);
        bag_period = 16'd4;
    endtask

    task automatic t_disable();
        bit still = 1'b1;
        // R9: disable with a grant held, release, re-enable from sub-link 0.
        serve(1, -1, "R9", -1);
        enable = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (!grant_valid || tx_start || grant_sel != 2'd1) still = 1'b0;
        end
        check(still, "R9", "held grant kept, no strobe while disabled", int'(still), 1);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check(!grant_valid, "R9", "grant released while disabled", int'(grant_valid), 0);
        repeat (5) @(negedge clk);
        check(!tx_start && !grant_valid, "R9", "no grant while disabled",
              int'(grant_valid), 0);
        enable = 1'b1;
        last_strobe = cyc;
        serve(0, 1, "R9", 0);
        serve(1, 4, "R5", 0);
    endtask

    initial begin
        t_reset();
        t_rotation();
        t_skip();
        t_idle();
        t_done_on_boundary();
        t_period();
        t_disable();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule